// File: doc/BRIEF.md
# Stalling Microprogram Fetch Unit

This block walks a microprogram held in a synchronous instruction RAM and hands one instruction per cycle to a fixed-latency execution pipeline. A start pulse launches the program from address 0. Each cycle the unit requests the word at its program counter and issues the returned word, or a no-operation if the read port has no valid data yet. Every issued word enters stage 0 of an instruction shift register. Downstream execution stages read that register to know which operation each stage holds. An end-of-program opcode stops the unit and produces a one-cycle completion pulse.

An arithmetic instruction (add, sub, mpy) takes several cycles to produce its result. A program normally has to pad each such instruction with filler no-operation words. This unit instead freezes itself for a configured number of cycles after issuing one. During that time the program counter, the RAM request and the shift register all hold. When the freeze ends, the unit requests the word again from the held address, which costs one warm-up no-operation.

Top module: `useq_fetch_unit`

The controller has three states:
- `ST_IDLE`: stopped; no-operations are shifted in and no RAM request is made.
- `ST_FETCH`: requesting and issuing words.
- `ST_STALL`: frozen for `EXEC_LAT` cycles.

The transitions are:
- start: `ST_IDLE` to `ST_FETCH`.
- end-of-program issued: `ST_FETCH` to `ST_IDLE`.
- arithmetic issued: `ST_FETCH` to `ST_STALL`.
- count expired: `ST_STALL` to `ST_FETCH`.

## Requirements
- R1: After a synchronous reset, `busy`, `stalled`, `done_pulse` and `rd_req` are low, `issue_word` is a no-operation, and every shift register stage holds a no-operation.
- R2: The opcode sits in word bits 19:16, the destination in 15:12 and three argument fields in 11:8, 7:4 and 3:0. The opcode codes are: end-of-program 0, nop 1, add 2, sub 3, mpy 4, save 5, load 6. A no-operation word is opcode 1 with all other bits zero, and an issued valid word is passed on unchanged.
- R3: A start request while idle makes `busy` high in the next cycle, with `rd_req` high and `rd_addr` equal to 0.
- R4: While fetching, the unit requests `rd_addr` equal to the program counter every cycle. It issues `rd_data` when `rd_valid` is high and a no-operation otherwise. After any issue that is neither arithmetic nor end-of-program, the counter advances by one, so a word whose data arrives without valid is skipped.
- R5: Issuing opcode 0 makes `busy` low in the next cycle, and `done_pulse` is high in that cycle only.
- R6: The instruction shift register has 9 stages. In every cycle in which the unit is not stalled, the issued word enters stage 0 and each stage k moves to stage k+1.
- R7: Issuing opcode 2, 3 or 4 holds the unit in `ST_STALL` for `EXEC_LAT` cycles (4 by default). During the stall, `stalled` is high, `rd_req` is low, `issue_word` is a no-operation, the program counter holds and the shift register keeps its contents.
- R8: In the first cycle after a stall, the unit requests the address of the word that followed the arithmetic instruction and issues one no-operation. The following word is issued in the next cycle.
- R9: A start request while `busy` is high has no effect on the instruction sequence or on the addresses requested.
- R10: While idle, `rd_req` is low and no-operations are shifted into the pipeline.
- R11: A reset asserted in the middle of a stall returns the unit to the R1 state, and a later start runs the program from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_req | input | 1 | Launch the program from address 0 |
| rd_req | output | 1 | Instruction RAM read request |
| rd_addr | output | PC_W (10) | Instruction RAM read address (program counter) |
| rd_valid | input | 1 | Read data valid for this cycle |
| rd_data | input | INSTR_W (20) | Read data from the instruction RAM |
| issue_word | output | INSTR_W (20) | Instruction issued this cycle |
| stage_words | output | PIPE_DEPTH*INSTR_W (180) | Shift register contents, stage k at bits k*INSTR_W upward |
| busy | output | 1 | Unit enabled (fetching or stalled) |
| stalled | output | 1 | Stall counter active |
| done_pulse | output | 1 | One-cycle end-of-program pulse |

## Verification
The bench builds the unit with its default parameters: 20-bit words, a 10-bit program counter, a 9-stage shift register and an execution latency of 4. It models a RAM that answers one cycle after each request. With a latency of 4, one stall is short enough to trace the issued word, the requested address and stage 0 cycle by cycle. A program of two back-to-back arithmetic instructions then shows the stall exit and re-entry twice in about fifteen cycles. The 9-stage depth keeps every stage observable, so checks on stages 1 to 3 confirm both the shifting and the freezing.

// File: rtl/useq_pkg.sv
package useq_pkg;

    typedef enum logic [3:0] {
        OP_END  = 4'd0,
        OP_NOP  = 4'd1,
        OP_ADD  = 4'd2,
        OP_SUB  = 4'd3,
        OP_MPY  = 4'd4,
        OP_SAVE = 4'd5,
        OP_LOAD = 4'd6
    } opcode_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_STALL = 2'd2
    } fetch_state_t;

    localparam int OPCODE_W = 4;

endpackage

// File: rtl/useq_decode.sv
module useq_decode
    import useq_pkg::*;
#(
    parameter int INSTR_W = 20
) (
    input  logic [INSTR_W-1:0] word,
    output logic               is_end,
    output logic               is_arith
);
    localparam int OP_LSB = INSTR_W - OPCODE_W;

    logic [OPCODE_W-1:0] op;

    always_comb begin
        op       = word[INSTR_W-1:OP_LSB];
        is_end   = (op == OP_END);
        is_arith = (op == OP_ADD) || (op == OP_SUB) || (op == OP_MPY);
    end

endmodule

// File: rtl/useq_ctrl.sv
module useq_ctrl
    import useq_pkg::*;
#(
    parameter int INSTR_W  = 20,
    parameter int PC_W     = 10,
    parameter int EXEC_LAT = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_req,
    input  logic               rd_valid,
    input  logic [INSTR_W-1:0] rd_data,
    input  logic               is_end,
    input  logic               is_arith,
    output logic               rd_req,
    output logic [PC_W-1:0]    rd_addr,
    output logic [INSTR_W-1:0] issue_word,
    output logic               advance,
    output logic               busy,
    output logic               stalled,
    output logic               done_pulse
);
    localparam int  OP_LSB   = INSTR_W - OPCODE_W;
    localparam int  CNT_W    = (EXEC_LAT > 0) ? $clog2(EXEC_LAT + 1) : 1;
    localparam bit  STALL_EN = (EXEC_LAT > 0);
    localparam logic [INSTR_W-1:0] NOP_WORD = {4'(OP_NOP), {OP_LSB{1'b0}}};

    fetch_state_t     state_q, state_d;
    logic [PC_W-1:0]  pc_q, pc_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             done_q, done_d;
    logic             word_ok;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pc_q    <= '0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            cnt_q   <= cnt_d;
            done_q  <= done_d;
        end
    end

    // outputs
    always_comb begin
        word_ok    = (state_q == ST_FETCH) && rd_valid;
        rd_req     = (state_q == ST_FETCH);
        rd_addr    = pc_q;
        issue_word = word_ok ? rd_data : NOP_WORD;
        advance    = (state_q != ST_STALL);
        busy       = (state_q != ST_IDLE);
        stalled    = (state_q == ST_STALL);
        done_pulse = done_q;
    end

    // next state
    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        cnt_d   = cnt_q;
        done_d  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_req) begin
                    state_d = ST_FETCH;
                    pc_d    = '0;
                    cnt_d   = '0;
                end
            end
            ST_FETCH: begin
                if (word_ok && is_end) begin
                    state_d = ST_IDLE;
                    done_d  = 1'b1;
                end else if (word_ok && is_arith && STALL_EN) begin
                    state_d = ST_STALL;
                    cnt_d   = CNT_W'(EXEC_LAT);
                end else begin
                    pc_d = pc_q + 1'b1;
                end
            end
            ST_STALL: begin
                cnt_d = cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    state_d = ST_FETCH;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R5

    AST_END_STOPS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FETCH && rd_valid && is_end) |=> (!busy && done_pulse)); // R5

    AST_NO_REQ_STALL: assert property (@(posedge clk) disable iff (rst)
        stalled |-> (!rd_req && issue_word == NOP_WORD)); // R7

    AST_PC_HELD_STALL: assert property (@(posedge clk) disable iff (rst)
        stalled |=> (rd_addr == $past(rd_addr))); // R7

    AST_STALL_AT_MOST: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(EXEC_LAT)); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!rd_req && issue_word == NOP_WORD)); // R10

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FETCH && start_req && !rd_valid) |=>
            (rd_addr == PC_W'($past(rd_addr) + 1'b1))); // R9

endmodule

// File: rtl/useq_shreg.sv
module useq_shreg
    import useq_pkg::*;
#(
    parameter int INSTR_W = 20,
    parameter int DEPTH   = 9
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     advance,
    input  logic [INSTR_W-1:0]       in_word,
    output logic [DEPTH*INSTR_W-1:0] stages
);
    localparam int OP_LSB = INSTR_W - OPCODE_W;
    localparam logic [INSTR_W-1:0] NOP_WORD = {4'(OP_NOP), {OP_LSB{1'b0}}};

    logic [INSTR_W-1:0] stage_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst)          stage_q[g] <= NOP_WORD;
                else if (advance) stage_q[g] <= in_word;
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (rst)          stage_q[g] <= NOP_WORD;
                else if (advance) stage_q[g] <= stage_q[g-1];
            end
        end
        assign stages[g*INSTR_W +: INSTR_W] = stage_q[g];
    end

    AST_FROZEN_HEAD: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(stages)); // R7

    AST_SHIFT_HEAD: assert property (@(posedge clk) disable iff (rst)
        advance |=> (stages[INSTR_W-1:0] == $past(in_word))); // R6

endmodule

// File: rtl/useq_fetch_unit.sv
module useq_fetch_unit
    import useq_pkg::*;
#(
    parameter int INSTR_W    = 20,
    parameter int PC_W       = 10,
    parameter int PIPE_DEPTH = 9,
    parameter int EXEC_LAT   = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start_req,
    output logic                          rd_req,
    output logic [PC_W-1:0]               rd_addr,
    input  logic                          rd_valid,
    input  logic [INSTR_W-1:0]            rd_data,
    output logic [INSTR_W-1:0]            issue_word,
    output logic [PIPE_DEPTH*INSTR_W-1:0] stage_words,
    output logic                          busy,
    output logic                          stalled,
    output logic                          done_pulse
);
    logic is_end;
    logic is_arith;
    logic advance;

    useq_decode #(.INSTR_W(INSTR_W)) u_decode (
        .word     (rd_data),
        .is_end   (is_end),
        .is_arith (is_arith)
    );

    useq_ctrl #(
        .INSTR_W  (INSTR_W),
        .PC_W     (PC_W),
        .EXEC_LAT (EXEC_LAT)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_req  (start_req),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .is_end     (is_end),
        .is_arith   (is_arith),
        .rd_req     (rd_req),
        .rd_addr    (rd_addr),
        .issue_word (issue_word),
        .advance    (advance),
        .busy       (busy),
        .stalled    (stalled),
        .done_pulse (done_pulse)
    );

    useq_shreg #(
        .INSTR_W (INSTR_W),
        .DEPTH   (PIPE_DEPTH)
    ) u_shreg (
        .clk     (clk),
        .rst     (rst),
        .advance (advance),
        .in_word (issue_word),
        .stages  (stage_words)
    );

endmodule

// File: tb/tb_useq_fetch_unit.sv
module tb_useq_fetch_unit;
    localparam int W = 20;
    localparam int PCW = 10;
    localparam int D = 9;
    localparam int LAT = 4;
    localparam int MAXC = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_req = 1'b0;
    logic rd_req;
    logic [PCW-1:0] rd_addr;
    logic rd_valid = 1'b0;
    logic [W-1:0] rd_data = '0;
    logic [W-1:0] issue_word;
    logic [D*W-1:0] stage_words;
    logic busy, stalled, done_pulse;
    logic kill_valid = 1'b0;
    logic [W-1:0] mem [0:31];

    int checks = 0;
    int errors = 0;
    int t_op [0:MAXC];
    int t_req [0:MAXC];
    int t_addr [0:MAXC];
    int t_busy [0:MAXC];
    int t_done [0:MAXC];
    int t_stall [0:MAXC];
    int t_s0 [0:MAXC];
    int t_s1 [0:MAXC];

    always #5 clk = ~clk;

    useq_fetch_unit dut (
        .clk(clk), .rst(rst), .start_req(start_req), .rd_req(rd_req),
        .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
        .issue_word(issue_word), .stage_words(stage_words), .busy(busy),
        .stalled(stalled), .done_pulse(done_pulse)
    );

    // one-cycle read latency instruction RAM
    always @(posedge clk) begin
        if (rst) rd_valid <= 1'b0;
        else     rd_valid <= rd_req & ~kill_valid;
        rd_data <= mem[rd_addr[4:0]];
    end

    function automatic logic [W-1:0] mk(int op, int d, int a1, int a2);
        return {op[3:0], d[3:0], a1[3:0], a2[3:0], 4'd0};
    endfunction

    function automatic int stage_op(int k);
        return int'(stage_words[k*W+16 +: 4]);
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 32; i++) mem[i] = mk(1, 0, 0, 0);
    endtask

    // start the program and record MAXC cycles
    task automatic run_prog(int kill_at, int poke_at);
        @(negedge clk);
        start_req = 1'b1;
        for (int c = 1; c <= MAXC; c++) begin
            @(negedge clk);
            start_req  = 1'b0;
            t_op[c]    = int'(issue_word[19:16]);
            t_req[c]   = int'(rd_req);
            t_addr[c]  = int'(rd_addr);
            t_busy[c]  = int'(busy);
            t_done[c]  = int'(done_pulse);
            t_stall[c] = int'(stalled);
            t_s0[c]    = stage_op(0);
            t_s1[c]    = stage_op(1);
            kill_valid = (c == kill_at);
            start_req  = (c == poke_at);
        end
        kill_valid = 1'b0;
        start_req  = 1'b0;
    endtask

    task automatic test_reset();
        chk("R1 busy", int'(busy), 0);
        chk("R1 stalled", int'(stalled), 0);
        chk("R1 done", int'(done_pulse), 0);
        chk("R1 rd_req", int'(rd_req), 0);
        chk("R1 issue nop", int'(issue_word), int'(mk(1, 0, 0, 0)));
        for (int k = 0; k < D; k++) chk("R1 stage nop", stage_op(k), 1);
    endtask

    task automatic test_basic();
        clear_mem();
        mem[0] = mk(6, 4, 9, 0);
        mem[1] = mk(5, 2, 10, 0);
        mem[2] = mk(0, 0, 0, 0);
        run_prog(0, 0);
        chk("R3 busy c1", t_busy[1], 1);
        chk("R3 req c1", t_req[1], 1);
        chk("R3 addr c1", t_addr[1], 0);
        chk("R4 warmup nop", t_op[1], 1);
        chk("R4 load issued", t_op[2], 6);
        chk("R4 addr c2", t_addr[2], 1);
        chk("R4 save issued", t_op[3], 5);
        chk("R4 addr c3", t_addr[3], 2);
        chk("R5 end issued", t_op[4], 0);
        chk("R5 busy c4", t_busy[4], 1);
        chk("R5 busy c5", t_busy[5], 0);
        chk("R5 done c5", t_done[5], 1);
        chk("R5 done c4", t_done[4], 0);
        chk("R5 done c6", t_done[6], 0);
        chk("R10 no req idle", t_req[5], 0);
        chk("R6 s0 c5", t_s0[5], 0);
        chk("R6 s1 c5", t_s1[5], 5);
        chk("R10 s0 idle nop", t_s0[6], 1);
        chk("R10 s1 idle", t_s1[6], 0);
        chk("R6 s3 end", stage_op(3), 1);
    endtask

    task automatic test_word_pass();
        clear_mem();
        mem[0] = mk(6, 3, 7, 11);
        mem[1] = mk(0, 0, 0, 0);
        @(negedge clk);
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        @(negedge clk);
        chk("R2 word unchanged", int'(issue_word), int'(mk(6, 3, 7, 11)));
        @(negedge clk);
        chk("R6 stage0 full word", int'(stage_words[W-1:0]), int'(mk(6, 3, 7, 11)));
        repeat (3) @(negedge clk);
    endtask

    task automatic test_stall();
        clear_mem();
        mem[0] = mk(2, 1, 4, 2);
        mem[1] = mk(5, 1, 12, 0);
        mem[2] = mk(0, 0, 0, 0);
        run_prog(0, 0);
        chk("R7 add issued", t_op[2], 2);
        for (int c = 3; c <= 6; c++) begin
            chk("R7 stalled", t_stall[c], 1);
            chk("R7 no req", t_req[c], 0);
            chk("R7 issue nop", t_op[c], 1);
            chk("R7 s0 frozen", t_s0[c], 2);
            chk("R7 s1 frozen", t_s1[c], 1);
            chk("R7 pc held", t_addr[c], 1);
        end
        chk("R8 stall ends", t_stall[7], 0);
        chk("R8 re-request", t_req[7], 1);
        chk("R8 re-request addr", t_addr[7], 1);
        chk("R8 warmup nop", t_op[7], 1);
        chk("R8 s0 at exit", t_s0[7], 2);
        chk("R8 s0 after exit", t_s0[8], 1);
        chk("R8 save issued", t_op[8], 5);
        chk("R5 end c9", t_op[9], 0);
        chk("R5 done c10", t_done[10], 1);
    endtask

    task automatic test_back_to_back();
        clear_mem();
        mem[0] = mk(4, 1, 1, 3);
        mem[1] = mk(3, 2, 1, 4);
        mem[2] = mk(0, 0, 0, 0);
        run_prog(0, 0);
        chk("R7 mpy issued", t_op[2], 4);
        chk("R8 nop c7", t_op[7], 1);
        chk("R7 sub issued", t_op[8], 3);
        chk("R7 stall c12", t_stall[12], 1);
        chk("R8 stall clear c13", t_stall[13], 0);
        chk("R8 addr c13", t_addr[13], 2);
        chk("R5 end c14", t_op[14], 0);
        chk("R5 done c15", t_done[15], 1);
    endtask

    task automatic test_valid_gap();
        clear_mem();
        mem[0] = mk(5, 1, 1, 0);
        mem[1] = mk(6, 2, 2, 0);
        mem[2] = mk(0, 0, 0, 0);
        run_prog(1, 0);
        chk("R4 invalid gives nop", t_op[2], 1);
        chk("R4 pc still advanced", t_addr[3], 2);
        chk("R4 word skipped", t_op[3], 6);
        chk("R4 end c4", t_op[4], 0);
        chk("R5 done c5", t_done[5], 1);
    endtask

    task automatic test_start_ignored();
        clear_mem();
        mem[4] = mk(0, 0, 0, 0);
        run_prog(0, 3);
        chk("R9 addr c5", t_addr[5], 4);
        chk("R9 end c6", t_op[6], 0);
        chk("R9 done c7", t_done[7], 1);
        chk("R9 busy c8", t_busy[8], 0);
    endtask

    task automatic test_reset_in_stall();
        clear_mem();
        mem[0] = mk(2, 1, 1, 1);
        mem[1] = mk(0, 0, 0, 0);
        @(negedge clk);
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        repeat (2) @(negedge clk);
        chk("R11 in stall", int'(stalled), 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R11 busy", int'(busy), 0);
        chk("R11 stalled", int'(stalled), 0);
        chk("R11 rd_req", int'(rd_req), 0);
        chk("R11 done", int'(done_pulse), 0);
        for (int k = 0; k < D; k++) chk("R11 stage nop", stage_op(k), 1);
        clear_mem();
        mem[0] = mk(6, 1, 1, 0);
        mem[1] = mk(0, 0, 0, 0);
        run_prog(0, 0);
        chk("R11 restart addr", t_addr[1], 0);
        chk("R11 restart load", t_op[2], 6);
        chk("R11 restart done", t_done[4], 1);
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        clear_mem();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_basic();
        test_word_pass();
        test_stall();
        test_back_to_back();
        test_valid_gap();
        test_start_ignored();
        test_reset_in_stall();
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule